// File: doc/BRIEF.md
# Timer Compare Toggle Output Channel

This block is one compare channel with its own free-running 16-bit timebase. When the channel is armed, its output pin changes level each time the timebase steps onto a programmed 16-bit compare value. The same event sets a sticky match flag. The flag raises an interrupt request when the channel's interrupt enable is set. A CPU reaches the channel through a byte-wide register port. Through this port it loads the compare value one byte at a time, programs the mode bits, reads the counter and reads or clears the flag.

Loading the low compare byte disarms the comparator, and loading the high byte arms it again. Software loads the low byte first and the high byte last. This way the comparator never acts on a compare value that is only half written. A match counts only when the timebase advances onto the compare value. A stopped timebase that rests on that value therefore does not toggle the pin again.

Top module: `cmp_toggle_chan`

## Requirements
- R1: The timebase is 16 bits wide. It adds one on every cycle in which `tick_en` is high, holds its value otherwise, and rolls over from 0xFFFF to 0x0000. Its low byte reads at address 4 and its high byte at address 5.
- R2: A hit occurs when four conditions are all true in the same cycle: `tick_en` is high, the comparator-enable bit is 1, the match-enable bit is 1, and the timebase's next value equals the compare register. A hit sets the match flag at that clock edge. The flag reads as bit 0 of address 1.
- R3: When the toggle-enable bit is also 1, a hit inverts `pin_out` at the same edge at which the timebase takes the compare value.
- R4: Hardware never clears the flag. Only a write to address 1 with bit 0 equal to 0 clears it. A write of 1 and any read leave it unchanged.
- R5: If a flag-clearing write and a hit fall in the same cycle, the flag stays 1.
- R6: `irq` is high exactly when the flag is 1 and the interrupt-enable bit is 1.
- R7: While the comparator-enable bit is 0, a timebase step onto the compare value neither toggles `pin_out` nor sets the flag.
- R8: The mode register sits at address 0, with bit 0 comparator enable, bit 1 match enable, bit 2 toggle enable and bit 3 interrupt enable. Bits 7..4 read as 0. A write to address 2 loads the compare low byte and forces bit 0 to 0. A write to address 3 loads the compare high byte and forces bit 0 to 1.
- R9: While `tick_en` is low, `pin_out` does not change, even when the timebase already equals the compare value.
- R10: After reset, `pin_out`, the flag, the mode bits, the compare register and the timebase are all 0.
- R11: `rdata` shows, one cycle later, the register selected by `addr`. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timebase advance enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Registered read data |
| pin_out | output | 1 | Toggle output |
| irq | output | 1 | Interrupt request |

## Verification
The bench loads a compare value one ahead of the timebase and then clears the flag in the very cycle of the hit. A design that lets the clear win loses the event. It also parks the timebase on the compare value with `tick_en` low. A level-sensitive comparator would then toggle the pin every cycle. A low-byte write that leaves the comparator armed shows up as a toggle on a half-loaded value. The bench also runs the timebase across its rollover. A counter that saturates or skips 0 would read back the wrong value there.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPLO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPHI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNTLO = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNTHI = 3'd5;

  typedef struct packed {
    logic ien;
    logic tog;
    logic mat;
    logic cen;
  } mode_t;
endpackage

// File: rtl/cmpt_timebase.sv
module cmpt_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt
);
  assign cnt_nxt = cnt + W'(1);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (adv) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/cmpt_match.sv
module cmpt_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] cmp,
  input  logic         cen,
  input  logic         mat,
  input  logic         tog,
  output logic         hit,
  output logic         pin
);
  // Edge-style detection: only a step onto the value counts.
  assign hit = adv && cen && mat && (cnt_nxt == cmp);

  always_ff @(posedge clk) begin
    if (rst)             pin <= 1'b0;
    else if (hit && tog) pin <= ~pin;
  end
endmodule

// File: rtl/cmpt_regs.sv
module cmpt_regs
  import cmpt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              hit,
  output mode_t             mode,
  output logic [2*DW-1:0]   cmp,
  output logic              flag
);
  localparam int LANES = 2;

  // Compare byte lanes, one per address.
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    localparam logic [ADDR_W-1:0] LANE_A = ADDR_W'(int'(A_CMPLO) + b);
    always_ff @(posedge clk) begin
      if (rst)                          cmp[b*DW +: DW] <= '0;
      else if (wr_en && addr == LANE_A) cmp[b*DW +: DW] <= wdata;
    end
  end

  // Mode bits; compare byte writes override the comparator enable.
  always_ff @(posedge clk) begin
    if (rst) mode <= '0;
    else if (wr_en) begin
      if (addr == A_MODE)       mode     <= mode_t'(wdata[3:0]);
      else if (addr == A_CMPLO) mode.cen <= 1'b0;
      else if (addr == A_CMPHI) mode.cen <= 1'b1;
    end
  end

  // Sticky flag; a hit outranks a clearing write.
  always_ff @(posedge clk) begin
    if (rst)       flag <= 1'b0;
    else if (hit)  flag <= 1'b1;
    else if (wr_en && addr == A_FLAG && !wdata[0]) flag <= 1'b0;
  end
endmodule

// File: rtl/cmp_toggle_chan.sv
module cmp_toggle_chan
  import cmpt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pin_out,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] cmp_q;
  mode_t            mode_q;
  logic             flag_q;
  logic             hit;

  cmpt_timebase #(.W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .adv(tick_en), .cnt(cnt_q), .cnt_nxt(cnt_nxt)
  );

  cmpt_match #(.W(CNT_W)) u_match (
    .clk(clk), .rst(rst), .adv(tick_en), .cnt_nxt(cnt_nxt), .cmp(cmp_q),
    .cen(mode_q.cen), .mat(mode_q.mat), .tog(mode_q.tog),
    .hit(hit), .pin(pin_out)
  );

  cmpt_regs #(.DW(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .hit(hit), .mode(mode_q), .cmp(cmp_q), .flag(flag_q)
  );

  assign irq = flag_q & mode_q.ien;

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        A_MODE:  rdata <= {{(DATA_W-4){1'b0}}, mode_q};
        A_FLAG:  rdata <= {{(DATA_W-1){1'b0}}, flag_q};
        A_CMPLO: rdata <= cmp_q[DATA_W-1:0];
        A_CMPHI: rdata <= cmp_q[CNT_W-1:DATA_W];
        A_CNTLO: rdata <= cnt_q[DATA_W-1:0];
        A_CNTHI: rdata <= cnt_q[CNT_W-1:DATA_W];
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cmpt_chk.sv
module cmpt_chk
  import cmpt_pkg::*;
#(
  parameter int CW = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wbit0,
  input logic [CW-1:0]     cnt,
  input logic [CW-1:0]     cmp,
  input logic              cen,
  input logic              mat,
  input logic              tog,
  input logic              flag,
  input logic              pin
);
  logic step_hit;
  logic clr_wr;
  assign step_hit = tick_en && cen && mat && ((cnt + CW'(1)) == cmp);
  assign clr_wr   = wr_en && addr == A_FLAG && !wbit0;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> cnt == $past(cnt) + CW'(1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt)); // R1
  AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    step_hit |=> flag); // R2
  AST_PIN_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (step_hit && tog) |=> pin != $past(pin)); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_wr) |=> flag); // R4
  AST_HIT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && step_hit) |=> flag); // R5
  AST_PIN_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    !cen |=> $stable(pin)); // R7
  AST_LO_DISARM: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CMPLO) |=> !cen); // R8
  AST_HI_ARM: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CMPHI) |=> cen); // R8
  AST_PIN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(pin)); // R9
endmodule

bind cmp_toggle_chan cmpt_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
  .wbit0(wdata[0]), .cnt(cnt_q), .cmp(cmp_q), .cen(mode_q.cen),
  .mat(mode_q.mat), .tog(mode_q.tog), .flag(flag_q), .pin(pin_out)
);

// File: tb/sim_cmp_toggle_chan.sv
module sim_cmp_toggle_chan;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pin_out;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [15:0] m_cnt, m_cmp;
  logic [3:0]  m_mode;
  logic        m_flag, m_pin;

  always #5 clk = ~clk;

  cmp_toggle_chan u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_out(pin_out), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rd_model(input logic [2:0] a);
    case (a)
      3'd0: return {4'h0, m_mode};
      3'd1: return {7'h0, m_flag};
      3'd2: return m_cmp[7:0];
      3'd3: return m_cmp[15:8];
      3'd4: return m_cnt[7:0];
      3'd5: return m_cnt[15:8];
      default: return 8'h00;
    endcase
  endfunction

  // One cycle: drive at negedge, apply the model at posedge, compare at the next negedge.
  task automatic step(input bit te, input bit w, input logic [2:0] a, input logic [7:0] d);
    logic [7:0] exp_rd;
    logic       hit;
    tick_en = te; wr_en = w; addr = a; wdata = d;
    exp_rd = rd_model(a);
    hit = te && m_mode[0] && m_mode[1] && (m_cnt + 16'd1 == m_cmp);
    @(posedge clk);
    if (te) m_cnt = m_cnt + 16'd1;
    if (hit && m_mode[2]) m_pin = ~m_pin;
    if (hit) m_flag = 1'b1;
    else if (w && a == 3'd1 && !d[0]) m_flag = 1'b0;
    if (w) begin
      case (a)
        3'd0: m_mode = d[3:0];
        3'd2: begin m_cmp[7:0]  = d; m_mode[0] = 1'b0; end
        3'd3: begin m_cmp[15:8] = d; m_mode[0] = 1'b1; end
        default: ;
      endcase
    end
    @(negedge clk);
    check("R3 pin_out", {15'h0, pin_out}, {15'h0, m_pin});
    check("R6 irq", {15'h0, irq}, {15'h0, m_flag & m_mode[3]});
    check("R11 rdata", {8'h0, rdata}, {8'h0, exp_rd});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_v;
    bit force_hi;
    m_cnt = '0; m_cmp = '0; m_mode = '0; m_flag = 1'b0; m_pin = 1'b0;
    seed_v = $urandom(32'd7341);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check("R10 pin_out reset", {15'h0, pin_out}, 16'h0);
    check("R10 irq reset", {15'h0, irq}, 16'h0);
    for (int a = 0; a < 8; a++) begin
      step(0, 0, 3'(a), 8'h00);
      check("R10 register reset", {8'h0, rdata}, 16'h0);
    end
    // R8: compare byte writes drive the comparator enable
    step(0, 1, 3'd0, 8'hFF);
    step(0, 0, 3'd0, 8'h00);
    check("R8 mode upper bits", {8'h0, rdata}, 16'h000F);
    step(0, 1, 3'd2, 8'h05);
    step(0, 0, 3'd0, 8'h00);
    check("R8 low byte disarms", {8'h0, rdata}, 16'h000E);
    step(0, 1, 3'd3, 8'h00);
    step(0, 0, 3'd0, 8'h00);
    check("R8 high byte arms", {8'h0, rdata}, 16'h000F);
    // R2/R3: step onto 0x0005
    for (int i = 0; i < 5; i++) step(1, 0, 3'd1, 8'h00);
    check("R3 toggle on hit", {15'h0, pin_out}, 16'h1);
    step(0, 0, 3'd1, 8'h00);
    check("R2 flag set", {8'h0, rdata}, 16'h1);
    // R9: parked on compare value
    for (int i = 0; i < 4; i++) step(0, 0, 3'd4, 8'h00);
    check("R9 no retoggle when stopped", {15'h0, pin_out}, 16'h1);
    // R4: sticky flag
    step(0, 1, 3'd1, 8'h01);
    step(0, 0, 3'd1, 8'h00);
    check("R4 write 1 keeps flag", {8'h0, rdata}, 16'h1);
    step(0, 1, 3'd1, 8'hFE);
    step(0, 0, 3'd1, 8'h00);
    check("R4 write 0 clears flag", {8'h0, rdata}, 16'h0);
    // R5: hit and clear in the same cycle
    step(0, 1, 3'd2, 8'h06);
    step(0, 1, 3'd3, 8'h00);
    step(1, 1, 3'd1, 8'h00);
    step(0, 0, 3'd1, 8'h00);
    check("R5 hit beats clear", {8'h0, rdata}, 16'h1);
    // R7: disarmed comparator
    step(0, 1, 3'd1, 8'h00);
    step(0, 1, 3'd2, 8'h07);
    step(1, 0, 3'd1, 8'h00);
    check("R7 pin holds disarmed", {15'h0, pin_out}, 16'h0);
    step(0, 0, 3'd1, 8'h00);
    check("R7 flag not set disarmed", {8'h0, rdata}, 16'h0);
    // R1: rollover
    while (m_cnt != 16'hFFFF) step(1, 0, 3'd4, 8'h00);
    step(1, 0, 3'd4, 8'h00);
    step(0, 0, 3'd4, 8'h00);
    check("R1 wrap low byte", {8'h0, rdata}, 16'h0);
    step(0, 0, 3'd5, 8'h00);
    check("R1 wrap high byte", {8'h0, rdata}, 16'h0);
    // Random phase
    force_hi = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      bit te, w;
      logic [2:0] a;
      logic [7:0] d;
      te = ($urandom % 4) != 0;
      w  = ($urandom % 5) == 0;
      a  = 3'($urandom % 8);
      d  = 8'($urandom);
      if (force_hi) begin w = 1'b1; a = 3'd3; d = m_cnt[15:8]; end
      else if (w && a == 3'd2) d = m_cnt[7:0] + 8'($urandom % 6) + 8'd2;
      else if (w && a == 3'd0 && ($urandom % 2) == 0) d[2:0] = 3'b111;
      force_hi = w && a == 3'd2;
      step(te, w, a, d);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule